// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block answers as a target on a two-wire serial bus and stores data in a 128-byte array of 8-bit words. The clock and data lines arrive as plain inputs. They are sampled in the system clock domain through synchronizer flops. The block pulls the data line low only through an open-drain enable output. It recognises bus framing conditions, assembles bytes most significant bit first, and acknowledges what it receives. It also serves read data back to the bus controller.

A write names a word address and then streams data bytes into a page buffer with 16 slots. The buffer is written into the array only when a Stop closes the transfer. A programming interval follows, and during it the target ignores every byte, including its own control byte. A read returns bytes from an internal pointer that advances after each byte and wraps at the end of the array. The controller ends the read by leaving the acknowledge bit high.

Top module: `i2c_eeprom_tgt`

## Requirements
- R1: After reset `sda_oe_o` is 0 and every one of the 128 array words reads back as 8'h00.
- R2: A Start (data line falling while the clock line is high) restarts byte framing from any state, including part way through a byte. A Stop (data line rising while the clock line is high) returns the target to idle.
- R3: The first byte after a Start is a control byte sent MSB first. Bits 7:4 must equal 4'b1010, bits 3:1 are ignored, and bit 0 selects read (1) or write (0). A matching byte is acknowledged by holding the data line low through the high phase of the ninth clock pulse. Any other code is left unacknowledged, and the target stays silent until the next Start.
- R4: In a write, the byte after the control byte is the word address, and its bits 6:0 are used. That byte and every data byte after it are acknowledged.
- R5: Data byte k of a write (counting from 0) goes to page bits 6:4 of the word address, slot (address[3:0] + k) mod 16. Later bytes overwrite earlier ones, so only the last 16 are kept. Nothing reaches the array unless the transfer ends in a Stop while still in write data; a repeated Start into a read discards the buffered bytes.
- R6: For PROG_CYCLES system clocks after a committing Stop, the target acknowledges no byte, control bytes included.
- R7: A read sends array bytes MSB first, starting at the pointer. The pointer is loaded by the last word address or follows on from the previous read. It advances after each byte and wraps from 127 to 0.
- R8: When the controller leaves the ninth bit of a read byte high, the target releases the data line and drives nothing more until the next Start.
- R9: `sda_oe_o` changes only in response to a falling clock line, a Start or a Stop, and never in the middle of a clock-high phase.
- R10: A write that ends with a Stop after only the word address starts no programming interval. A control byte sent straight afterwards is acknowledged, and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Each bus edge takes two synchronizer flops plus one state register to reach `sda_oe_o`, so an acknowledge or read bit appears three system clocks after the clock line falls. The bench holds every bus phase for at least five system clocks. It reads the wire in the middle of each ten-clock high phase, well after the response has settled. The programming interval is counted from the Stop seen through the same three-clock path. The bench therefore probes for the refused acknowledge with a control byte sent right after the Stop, well inside PROG_CYCLES. It waits PROG_CYCLES plus a margin before reading back.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } st_e;
endpackage

// File: rtl/i2c_eep_bus_sync.sv
module i2c_eep_bus_sync #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_q  <= scl_ff[SYNC-1];
      sda_q  <= sda_ff[SYNC-1];
    end
  end

  assign scl_s      = scl_ff[SYNC-1];
  assign sda_s      = sda_ff[SYNC-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_eep_page_buf.sv
module i2c_eep_page_buf #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int PAGE = 16,
  localparam int SW  = $clog2(PAGE),
  localparam int PW  = AW - SW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [AW-1:0]            base_i,
  input  logic                     push_i,
  input  logic [DW-1:0]            data_i,
  output logic [PW-1:0]            page_o,
  output logic [PAGE-1:0][DW-1:0]  slot_data_o,
  output logic [PAGE-1:0]          slot_vld_o
);
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o      <= '0;
      slot_q      <= '0;
      slot_vld_o  <= '0;
      slot_data_o <= '0;
    end else if (load_i) begin
      page_o     <= base_i[AW-1:SW];
      slot_q     <= base_i[SW-1:0];
      slot_vld_o <= '0;
    end else if (push_i) begin
      slot_data_o[slot_q] <= data_i;
      slot_vld_o[slot_q]  <= 1'b1;
      slot_q              <= slot_q + 1'b1;  // rolls within the page
    end
  end
endmodule

// File: rtl/i2c_eep_mem.sv
module i2c_eep_mem #(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int PAGE  = 16,
  localparam int SW   = $clog2(PAGE),
  localparam int PW   = AW - SW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [PW-1:0]           page_i,
  input  logic [PAGE-1:0][DW-1:0] slot_data_i,
  input  logic [PAGE-1:0]         slot_vld_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [DW-1:0]           rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int s = 0; s < PAGE; s++)
        if (slot_vld_i[s]) mem_q[{page_i, SW'(s)}] <= slot_data_i[s];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_eeprom_tgt.sv
module i2c_eeprom_tgt
  import i2c_eep_pkg::*;
#(
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter int         PAGE        = 16,
  parameter int         PROG_CYCLES = 5000,
  parameter int         SYNC        = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int SW = $clog2(PAGE);
  localparam int PW = AW - SW;
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam int BW = $clog2(DW + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  st_q, nxt_q;
  logic [DW-1:0] shreg_q, tx_q, rd_data;
  logic [BW-1:0] bit_cnt_q;
  logic          ack_ph_q, mack_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] busy_cnt_q;
  logic          busy, rx_st, rx_done, pb_load, pb_push, commit;
  logic [PW-1:0]           pb_page;
  logic [PAGE-1:0][DW-1:0] pb_data;
  logic [PAGE-1:0]         pb_vld;

  i2c_eep_bus_sync #(.SYNC(SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_eep_page_buf #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_pbuf (
    .clk_i, .rst_ni, .load_i(pb_load), .base_i(shreg_q[AW-1:0]),
    .push_i(pb_push), .data_i(shreg_q), .page_o(pb_page),
    .slot_data_o(pb_data), .slot_vld_o(pb_vld)
  );

  i2c_eep_mem #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_mem (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(pb_page),
    .slot_data_i(pb_data), .slot_vld_i(pb_vld),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  assign busy    = busy_cnt_q != '0;
  assign rx_st   = (st_q == ST_CTRL) || (st_q == ST_ADDR) || (st_q == ST_WDATA);
  assign rx_done = rx_st && !ack_ph_q && scl_fall && (bit_cnt_q == BW'(DW))
                   && !start_det && !stop_det;
  assign pb_load = rx_done && (st_q == ST_ADDR);
  assign pb_push = rx_done && (st_q == ST_WDATA);
  assign commit  = stop_det && (st_q == ST_WDATA) && (|pb_vld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (commit) busy_cnt_q <= CW'(PROG_CYCLES);
    else if (busy)   busy_cnt_q <= busy_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      shreg_q   <= '0;
      tx_q      <= '0;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      mack_q    <= 1'b0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
    end else if (start_det) begin
      st_q      <= ST_CTRL;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (stop_det) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      case (st_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (ack_ph_q) begin
            if (scl_fall) begin
              ack_ph_q  <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= nxt_q;
              tx_q      <= rd_data;
              sda_oe_o  <= (nxt_q == ST_RDATA) ? ~rd_data[DW-1] : 1'b0;
            end
          end else if (scl_rise && bit_cnt_q < BW'(DW)) begin
            shreg_q   <= {shreg_q[DW-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (rx_done) begin
            if (st_q == ST_CTRL) begin
              if (shreg_q[DW-1:DW-4] == DEV_CODE && !busy) begin
                ack_ph_q <= 1'b1;
                sda_oe_o <= 1'b1;
                nxt_q    <= shreg_q[0] ? ST_RDATA : ST_ADDR;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              ack_ph_q <= 1'b1;
              sda_oe_o <= 1'b1;
              nxt_q    <= ST_WDATA;
              if (st_q == ST_ADDR) ptr_q <= shreg_q[AW-1:0];
            end
          end
        end
        ST_RDATA: begin
          if (!ack_ph_q) begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt_q == BW'(DW)) begin
                sda_oe_o <= 1'b0;
                ack_ph_q <= 1'b1;
                ptr_q    <= ptr_q + 1'b1;  // wraps at the top
              end else begin
                tx_q     <= {tx_q[DW-2:0], 1'b0};
                sda_oe_o <= ~tx_q[DW-2];
              end
            end
          end else if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            ack_ph_q <= 1'b0;
            if (mack_q) begin
              tx_q      <= rd_data;
              sda_oe_o  <= ~rd_data[DW-1];
              bit_cnt_q <= '0;
            end else begin
              st_q     <= ST_IDLE;
              sda_oe_o <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_tgt_chk.sv
module i2c_eeprom_tgt_chk
  import i2c_eep_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_i,
  input logic scl_fall_i,
  input logic start_i,
  input logic stop_i,
  input logic busy_i,
  input st_e  st_i
);
  // R9: the open-drain enable only moves after a clock fall or a framing condition
  p_oe_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> $past(scl_fall_i || start_i || stop_i));

  // R6: silent for the whole programming interval
  p_busy_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  // R6: programming starts only from a Stop
  p_busy_from_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R3 / R8: nothing driven while idle
  p_idle_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i);

  // R2: a Start always lands in control-byte reception
  p_start_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_i == ST_CTRL) && !sda_oe_i);
endmodule

bind i2c_eeprom_tgt i2c_eeprom_tgt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_i   (sda_oe_o),
  .scl_fall_i (scl_fall),
  .start_i    (start_det),
  .stop_i     (stop_det),
  .busy_i     (busy),
  .st_i       (st_q)
);

// File: tb/i2c_eeprom_tgt_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_tgt_tb;
  localparam int PROG = 600;
  localparam int Q    = 10;
  localparam int H    = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int   errs = 0, checks = 0, r9_viol = 0, hi_cnt = 0;
  bit   done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] model [128];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_tgt #(.PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  // R9 monitor: enable must hold still once the clock has been high a while
  always @(negedge clk) begin
    hi_cnt <= scl_m ? hi_cnt + 1 : 0;
    if (rst_n && scl_m && hi_cnt > 4 && sda_oe !== prev_oe) r9_viol <= r9_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    scl_m = 1'b0; hw(H); sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(Q); sda_m = 1'b0; hw(Q); scl_m = 1'b0;
  endtask

  task automatic bstop();
    scl_m = 1'b0; hw(H); sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(Q); sda_m = 1'b1; hw(Q);
  endtask

  task automatic wbit(input logic b);
    scl_m = 1'b0; hw(H); sda_m = b; hw(H); scl_m = 1'b1; hw(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    scl_m = 1'b0; hw(H); sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H); ack = (sda_line == 1'b0); hw(H);
    scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; hw(Q); scl_m = 1'b1; hw(H); d[i] = sda_line; hw(H);
    end
    scl_m = 1'b0; hw(H); sda_m = ~mack; hw(H);
    scl_m = 1'b1; hw(Q); scl_m = 1'b0; hw(H); sda_m = 1'b1;
  endtask

  // write n bytes from address a; byte k = seed + 29k; model follows the page-slot rule
  task automatic page_wr(input logic [6:0] a, input int n, input int seed, input logic [7:0] ctl,
                         input string ctag);
    bit ack;
    logic [7:0] v;
    bstart();
    wbyte(ctl, ack);        chk(ack, ctag, ack, 1);
    wbyte({1'b0, a}, ack);  chk(ack, "R4 addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      v = 8'((seed + 29 * k) & 8'hFF);
      wbyte(v, ack);        chk(ack, "R4 data ack", ack, 1);
      model[{a[6:4], 4'((a[3:0] + k) % 16)}] = v;
    end
    bstop();
  endtask

  task automatic rd_chk(input logic [6:0] a, input int n, input string tag, input bit extra);
    bit ack;
    logic [7:0] d;
    bstart();
    wbyte(8'hA0, ack);      chk(ack, "R3 ctrl W ack", ack, 1);
    wbyte({1'b0, a}, ack);  chk(ack, "R4 addr ack", ack, 1);
    bstart();
    wbyte(8'hA1, ack);      chk(ack, "R3 ctrl R ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(d == model[7'((a + k) % 128)], tag, d, model[7'((a + k) % 128)]);
    end
    if (extra) begin
      rbyte(1'b0, d);       chk(d == 8'hFF, "R8 released after NACK", d, 8'hFF);
    end
    bstop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    hw(5);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hw(5);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    rd_chk(7'h00, 4, "R1 array cleared", 1'b0);

    // full array sweep, one page per write; first one probes the busy window
    for (int p = 0; p < 8; p++) begin
      page_wr(7'(p * 16), 16, p * 37 + 11, 8'hA0, "R3 ctrl ack");
      if (p == 0) begin
        bstart(); wbyte(8'hA0, ack); chk(!ack, "R6 ctrl W nack while busy", ack, 0); bstop();
        bstart(); wbyte(8'hA1, ack); chk(!ack, "R6 ctrl R nack while busy", ack, 0); bstop();
      end
      hw(PROG + 50);
    end
    // sequential read of all words, past the end to check the wrap, then NACK release
    rd_chk(7'h00, 130, "R7 sequential read/wrap", 1'b1);

    // 20 bytes into one page: only the last 16 survive (R5)
    page_wr(7'h25, 20, 8'hA0, 8'hAE, "R3 ctrl ack, ignored bits");
    hw(PROG + 50);
    rd_chk(7'h1F, 18, "R5 page roll-over", 1'b0);

    // current-address read continues from the pointer (R7)
    rd_chk(7'h7E, 2, "R7 random read", 1'b0);
    bstart(); wbyte(8'hA1, ack); chk(ack, "R7 cur read ack", ack, 1);
    rbyte(1'b0, d); chk(d == model[0], "R7 current address", d, model[0]); bstop();

    // repeated start into read discards buffered data (R5)
    bstart();
    wbyte(8'hA0, ack); wbyte(8'h50, ack); wbyte(8'h5A, ack);
    chk(ack, "R4 data ack", ack, 1);
    bstart();
    wbyte(8'hA1, ack); chk(ack, "R5 restart read ack", ack, 1);
    rbyte(1'b0, d); chk(d == model[8'h50], "R5 no commit without stop", d, model[8'h50]);
    bstop();

    // address-only write: no programming interval (R10)
    bstart(); wbyte(8'hA0, ack); wbyte(8'h40, ack); bstop();
    bstart(); wbyte(8'hA0, ack); chk(ack, "R10 ack right after addr-only", ack, 1); bstop();
    rd_chk(7'h40, 1, "R10 array unchanged", 1'b0);

    // wrong device codes are never acknowledged (R3)
    for (int c = 0; c < 16; c++) begin
      if (c != 4'hA) begin
        bstart(); wbyte({4'(c), 4'h0}, ack);
        chk(!ack, "R3 foreign code nack", ack, 0);
        bstop();
      end
    end

    // Start mid-byte restarts framing (R2)
    bstart(); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    page_wr(7'h10, 1, 8'h77, 8'hA0, "R2 ctrl ack after mid-byte start");
    hw(PROG + 50);
    rd_chk(7'h10, 1, "R2 write after restart", 1'b0);

    chk(r9_viol == 0, "R9 oe stable in clock high", r9_viol, 0);
    hw(10);
    finish_run();
  end
endmodule